// File: doc/BRIEF.md
# Serial Two-Wire EEPROM Slave

This block is a synthesizable two-wire (I2C) slave in front of a 2048-byte storage array. The array is split into eight 256-byte banks and held in an internal register array. The block sees the bus lines through synchronisers clocked by the system clock. It detects START and STOP conditions and decodes a device select byte against three strap inputs. It then takes a two-byte memory address, receives or returns data bytes, and drives SDA only as an open-drain pull-low enable.

Writes are collected in a 16-byte page buffer. They reach the array only when the master closes the transfer with STOP. The block then enters a self-timed busy period of programmable length. During that period it ignores the bus entirely. Reads return bytes from an address counter that advances after every byte, so the master can do current-address, random and sequential reads. A write-lock input lets a host protect the array: the select and address bytes are still acknowledged, but data bytes are refused.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_pull_o` = 0), every array byte reads 0xFF and the address counter is 0.
- R2: A START (SDA falling while SCL is high) is recognised at any point, including in the middle of a byte, and restarts device select reception; a STOP (SDA rising while SCL is high) ends any transfer.
- R3: The device select byte arrives MSB first; bits 7..4 must be 4'b1010 and bits 3..1 must equal `chip_sel_i[2:0]`, with bit 0 as the direction (1 = read, 0 = write); a matching byte is acknowledged by pulling SDA low during the 9th clock, and a non-matching byte is not acknowledged and everything up to the next START is ignored.
- R4: The memory address is sent as two bytes, high byte first; only bits 10..0 of the 16-bit value are used and the upper five bits are ignored.
- R5: A byte write (select with bit 0 = 0, two address bytes, one data byte, STOP) stores the data byte at the address, and each received address and data byte is acknowledged.
- R6: A page write accepts data bytes in sequence, advancing only the low four address bits so that the address wraps inside its 16-byte aligned page; a later byte landing on an already filled column replaces the earlier one, and bytes outside the page are untouched.
- R7: Buffered data reaches the array only on STOP; a repeated START discards buffered data, and a transfer without any accepted data byte starts no busy period.
- R8: After a STOP that commits data, the slave ignores the bus for `BUSY_CYCLES` system clocks and does not acknowledge a device select; afterwards it responds again.
- R9: While `wr_lock_i` is 1, the device select and address bytes are acknowledged, but data bytes are not acknowledged, the array is unchanged and no busy period follows.
- R10: A current-address read (select with bit 0 = 1 right after START) returns the byte at the address counter; the counter advances by one after each byte sent, and after a write it points past the last written column within the page.
- R11: A random read (write select, two address bytes, repeated START, read select) returns the byte at the given address.
- R12: A sequential read continues while the master acknowledges, advancing the address and wrapping from 2047 to 0; when the master does not acknowledge, the slave releases SDA and stays silent until the next START.
- R13: The slave changes its SDA drive only while SCL is low and samples SDA on the rising edge of SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL by at least eight times |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| chip_sel_i | input | 3 | Strap value compared with device select bits 3..1 |
| wr_lock_i | input | 1 | 1 = refuse data bytes and protect the array |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
Every bus-visible result of the slave arrives three system clocks after the SCL edge that causes it: two synchroniser stages, then the state register. The bench therefore drives SCL in quarter periods of six clocks and reads SDA one quarter after SCL rises, well after the slave's drive has settled. A committed write becomes visible in the array one clock after STOP is seen. The busy period then lasts `BUSY_CYCLES` clocks, so the bench polls right after STOP to see the refusal and waits a margin beyond that count before reading data back. A monitor in the bench records every change of the pull-low enable and flags any that happen while SCL is held high.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_FAMILY = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK,
        ST_BUSY
    } ee_state_e;

endpackage

// File: rtl/i2c_ee_linemon.sv
module i2c_ee_linemon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign scl_lvl  = lvl[1];
    assign sda_lvl  = lvl[0];
    assign scl_rise = lvl[1] & ~prev_q[1];
    assign scl_fall = ~lvl[1] & prev_q[1];
    assign start_ev = lvl[1] & prev_q[1] & prev_q[0] & ~lvl[0];
    assign stop_ev  = lvl[1] & prev_q[1] & ~prev_q[0] & lvl[0];

endmodule

// File: rtl/i2c_ee_busy.sv
module i2c_ee_busy #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter logic [7:0] FILL = 8'hFF
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [7:0]                         rd_data,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_W-1:0]           commit_page,
    input  logic [(1<<PAGE_W)-1:0][7:0]        commit_data,
    input  logic [(1<<PAGE_W)-1:0]             commit_mask
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= FILL;
        end else if (commit) begin
            for (int c = 0; c < PAGE_BYTES; c++) begin
                if (commit_mask[c]) mem_q[{commit_page, PAGE_W'(c)}] <= commit_data[c];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int HI_W       = ADDR_W - 8;

    typedef struct packed {
        ee_state_e                    state;
        ee_state_e                    nxt;
        logic [3:0]                   cnt;
        logic [7:0]                   sh;
        logic [7:0]                   tx;
        logic                         pull;
        logic                         ack_m;
        logic [HI_W-1:0]              ahi;
        logic [ADDR_W-1:0]            addr;
        logic [PAGE_BYTES-1:0][7:0]   wbuf;
        logic [PAGE_BYTES-1:0]        vld;
    } regs_t;

    regs_t q, n;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic busy, commit;
    logic [7:0] rd_data;
    logic match;
    logic [PAGE_W-1:0] col;

    i2c_ee_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
    );

    i2c_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(q.addr), .rd_data(rd_data),
        .commit(commit), .commit_page(q.addr[ADDR_W-1:PAGE_W]),
        .commit_data(q.wbuf), .commit_mask(q.vld)
    );

    assign match = (q.sh[7:4] == DEV_FAMILY) && (q.sh[3:1] == chip_sel_i);
    assign col   = q.addr[PAGE_W-1:0];

    always_comb begin
        n      = q;
        commit = 1'b0;
        if (q.state == ST_BUSY) begin
            // deaf to the bus until the self-timed period ends
            if (!busy) n.state = ST_IDLE;
        end else if (start_ev) begin
            n.state = ST_DEV;
            n.cnt   = '0;
            n.pull  = 1'b0;
            n.vld   = '0;
        end else if (stop_ev) begin
            n.pull = 1'b0;
            if (|q.vld) begin
                commit  = 1'b1;
                n.vld   = '0;
                n.state = ST_BUSY;
            end else begin
                n.state = ST_IDLE;
            end
        end else begin
            case (q.state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[6:0], sda_lvl};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        n.cnt   = '0;
                        n.state = ST_ACK;
                        n.pull  = 1'b1;
                        case (q.state)
                            ST_DEV: begin
                                if (match) begin
                                    n.nxt = q.sh[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    n.state = ST_IDLE;
                                    n.pull  = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                n.ahi = q.sh[HI_W-1:0];
                                n.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                n.addr = {q.ahi, q.sh};
                                n.nxt  = ST_WDAT;
                            end
                            default: begin
                                n.nxt = ST_WDAT;
                                if (wr_lock_i) begin
                                    n.pull = 1'b0;
                                end else begin
                                    n.wbuf[col] = q.sh;
                                    n.vld[col]  = 1'b1;
                                    n.addr      = {q.addr[ADDR_W-1:PAGE_W], col + PAGE_W'(1)};
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.pull  = 1'b0;
                        n.state = q.nxt;
                        n.cnt   = '0;
                        if (q.nxt == ST_RDAT) begin
                            n.tx   = rd_data;
                            n.pull = ~rd_data[7];
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.pull  = 1'b0;
                            n.state = ST_RACK;
                            n.cnt   = '0;
                            n.addr  = q.addr + ADDR_W'(1);
                        end else begin
                            n.cnt  = q.cnt + 4'd1;
                            n.tx   = {q.tx[6:0], 1'b0};
                            n.pull = ~q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        n.ack_m = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.ack_m) begin
                            n.state = ST_RDAT;
                            n.tx    = rd_data;
                            n.pull  = ~rd_data[7];
                        end else begin
                            n.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_pull_o = q.pull;

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_pull,
    input logic       busy,
    input logic       stop_ev,
    input logic [3:0] bit_cnt
);
    // R8: no drive at all while the self-timed period runs
    a_r8_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull);

    // R13: the drive changes only after SCL was seen low
    a_r13_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(!scl_lvl));

    // R7: a busy period begins only right after a STOP
    a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

    // R3: a byte never holds more than eight bits
    a_r3_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

endmodule

bind i2c_eeprom_slave i2c_ee_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull_o),
    .busy(busy), .stop_ev(stop_ev), .bit_cnt(q.cnt)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
module i2c_eeprom_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int BUSY       = 1000;
    localparam int WD_CYCLES  = 180000;
    localparam logic [2:0] CS = 3'b101;

    localparam logic [23:0] VEC [6] = '{
        {16'hF800, 8'h5A}, {16'h0005, 8'hA5}, {16'h03C7, 8'h3C},
        {16'hA4B2, 8'h81}, {16'h07FF, 8'h99}, {16'h07FE, 8'h17}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_pull;
    wire  sda_bus = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_fail = 0;
    int r13_viol = 0;
    logic pull_prev = 1'b0;
    logic scl_prev = 1'b1;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_slave #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .chip_sel_i(CS), .wr_lock_i(wr_lock), .sda_pull_o(sda_pull)
    );

    // R13 monitor: a drive change with SCL high on both sides is a violation
    always @(posedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_pull !== pull_prev)) r13_viol++;
        pull_prev <= sda_pull;
        scl_prev  <= scl_m;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        tick(Q); sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(2*Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~more);
    endtask

    function automatic logic [7:0] dsel(input logic [2:0] cs, input logic rd);
        return {4'b1010, cs, rd};
    endfunction

    // write select + two address bytes; ok = all three acknowledged
    task automatic addr_phase(input logic [15:0] a, output logic ok);
        logic k0, k1, k2;
        bus_start();
        put_byte(dsel(CS, 1'b0), k0);
        put_byte(a[15:8], k1);
        put_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic page_write(input logic [15:0] a, input int cnt, input logic [7:0] first,
                              output logic ok);
        logic k;
        addr_phase(a, ok);
        for (int i = 0; i < cnt; i++) begin
            put_byte(first + 8'(i), k);
            ok &= k;
        end
        bus_stop();
    endtask

    // random read: address phase, repeated START, read select
    task automatic rand_begin(input logic [15:0] a, output logic ok);
        logic k;
        addr_phase(a, ok);
        bus_start();
        put_byte(dsel(CS, 1'b1), k);
        ok &= k;
    endtask

    task automatic rand_read(input logic [15:0] a, output logic [7:0] v, output logic ok);
        rand_begin(a, ok);
        get_byte(v, 1'b0);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] v, output logic ok);
        bus_start();
        put_byte(dsel(CS, 1'b1), ok);
        get_byte(v, 1'b0);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic ok, k, b;
        logic [7:0] v;
        logic [10:0] ea;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        check("R1 sda released after reset", sda_pull, 0);
        cur_read(v, ok);
        check("R1 counter zero, array erased", v, 8'hFF);

        // table of byte writes read back by random reads
        for (int i = 0; i < 6; i++) begin
            ea = VEC[i][18:8];
            page_write(VEC[i][23:8], 1, VEC[i][7:0], ok);
            check("R5 byte write acks", ok, 1);
            tick(BUSY + 50);
            rand_read({5'b0, ea}, v, ok);
            check("R11 random read select acked", ok, 1);
            check("R4 R5 stored at low 11 address bits", v, VEC[i][7:0]);
        end

        // R10: counter now at 0x7FF, then wraps to 0x000
        cur_read(v, ok);
        check("R10 current read at counter", v, 8'h99);
        cur_read(v, ok);
        check("R10 R12 counter wrapped to 0", v, 8'h5A);

        // R12: sequential read across the top of the array
        rand_begin(16'h07FF, ok);
        get_byte(v, 1'b1);
        check("R12 seq byte at 2047", v, 8'h99);
        get_byte(v, 1'b1);
        check("R12 seq wrap to address 0", v, 8'h5A);
        get_byte(v, 1'b0);
        check("R12 seq byte at 1", v, 8'hFF);
        for (int i = 0; i < 3; i++) begin
            get_bit(b);
            check("R12 SDA released after master nack", b, 1);
        end
        bus_stop();

        // R6: 18 bytes from column 3 of page 0x120 wrap inside the page
        page_write(16'h0123, 18, 8'h40, ok);
        check("R6 page write acks", ok, 1);
        tick(BUSY + 50);
        rand_begin(16'h0120, ok);
        for (int c = 0; c < 17; c++) begin
            int idx;
            get_byte(v, c < 16);
            if (c < 16) begin
                idx = (c - 3) & 15;
                if (idx + 16 < 18) idx += 16;
                check("R6 page column content", v, 8'h40 + idx);
            end else begin
                check("R6 next page untouched", v, 8'hFF);
            end
        end
        bus_stop();

        // R7: repeated START discards buffered data, no busy period
        addr_phase(16'h0050, ok);
        put_byte(8'h77, k);
        check("R7 data byte acked before restart", k, 1);
        rand_begin(16'h0050, ok);
        check("R7 no busy after discarded data", ok, 1);
        get_byte(v, 1'b0);
        bus_stop();
        check("R7 discarded byte not stored", v, 8'hFF);

        // R8: busy period refuses the bus
        page_write(16'h0060, 1, 8'hC3, ok);
        bus_start();
        put_byte(dsel(CS, 1'b0), k);
        bus_stop();
        check("R8 select refused while busy", k, 0);
        tick(BUSY + 50);
        rand_read(16'h0060, v, ok);
        check("R8 select acked after busy", ok, 1);
        check("R8 committed byte readable", v, 8'hC3);

        // R9: write lock
        wr_lock = 1'b1;
        addr_phase(16'h0070, ok);
        check("R9 select and address acked under lock", ok, 1);
        put_byte(8'h5C, k);
        check("R9 data refused under lock", k, 0);
        bus_stop();
        wr_lock = 1'b0;
        rand_read(16'h0070, v, ok);
        check("R9 no busy after locked write", ok, 1);
        check("R9 array unchanged", v, 8'hFF);

        // R2: START in the middle of a data byte
        addr_phase(16'h0080, ok);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(dsel(CS, 1'b1), k);
        check("R2 select after mid-byte START acked", k, 1);
        get_byte(v, 1'b0);
        bus_stop();
        check("R2 partial byte not stored", v, 8'hFF);

        // R3: select decoding
        bus_start();
        put_byte(dsel(3'b100, 1'b0), k);
        check("R3 wrong strap refused", k, 0);
        put_byte(8'h00, k);
        check("R3 bytes ignored after mismatch", k, 0);
        bus_stop();
        bus_start();
        put_byte({4'b1011, CS, 1'b1}, k);
        bus_stop();
        check("R3 wrong family refused", k, 0);
        bus_start();
        put_byte(dsel(CS, 1'b0), k);
        bus_stop();
        check("R3 matching select acked", k, 1);

        // R1: reset in service clears the array
        tick(10);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(5);
        rand_read(16'h0005, v, ok);
        check("R1 array erased by reset", v, 8'hFF);

        check("R13 drive changed while SCL high", r13_viol, 0);

        done = 1'b1;
        finish_run();
    end

endmodule